// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM with FIFO Controller

This block is a 4,608-bit on-chip memory with one write port and one read port. The data width of each port is chosen on its own, so a producer can store narrow words and a consumer can fetch wide ones, or the other way round. Both ports are synchronous. A read returns its data one clock after the request.

A mode input turns the same storage into a synchronous FIFO. In that mode, internal counters supply both addresses. Pushes and pops take the place of the port enables. Four occupancy flags are driven from a fill level counted in bits: full, empty, and two early warnings whose trip points come from threshold inputs. A push refused because the FIFO is full, or a pop refused because it is empty, is dropped and leaves a sticky error flag set. The flag stays set until reset.

A port of 1, 2 or 4 bits addresses 4,096 bits. A port of 9 or 18 bits addresses all 4,608 bits. Mixed widths are always allowed in RAM mode. FIFO mode expects both widths from the same group: {1,2,4} or {9,18}.

Top module: `mwram_fifo`

## Requirements
- R1: Each port width is a parameter taking one of 1, 2, 4, 9 or 18. The port depth is 4096/width for widths up to 4 and 4608/width for widths 9 and 18, so every address up to depth-1 is usable.
- R2: Bit k of the word at address a on a port of width w is logical memory bit a*w+k. Within a group, a word written on one port therefore lands in ascending positions of a wider word on the other port, with the lowest narrow address in the least significant bits.
- R3: In RAM mode, a read requested at a clock edge drives rd_data and raises rd_valid after that same edge. With no read, rd_valid is low and rd_data keeps its last value.
- R4: When a write and a read hit the same location at the same edge, the read returns the contents from before the write.
- R5: When fifo_en is 1, pushed words come out in push order. A wide pushed word comes out narrow piece by piece, least significant first. In this mode wr_en, rd_en, wr_addr and rd_addr have no effect.
- R6: empty is 1 when fewer than RD_W bits are stored. full is 1 when fewer than WR_W bits are free.
- R7: almost_empty is 1 when the number of whole read words stored is at most ae_level. almost_full is 1 when the number of whole write words that still fit is at most af_level.
- R8: A push while full is dropped and stored data are unchanged. The same push sets overflow, which stays 1 until reset.
- R9: A pop while empty is dropped and does not raise rd_valid. The same pop sets underflow, which stays 1 until reset.
- R10: A push and a pop in the same cycle, neither blocked, both take effect. The fill level moves by WR_W-RD_W bits.
- R11: When fifo_en is 0, push and pop have no effect, and the fill level returns to zero after one clock, so empty reads 1.
- R12: After reset, rd_valid, rd_data, full, overflow and underflow are 0 and empty is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects RAM mode |
| wr_en | input | 1 | RAM-mode write request |
| wr_addr | input | WAW | RAM-mode write address |
| wr_data | input | WR_W | Write data, used in both modes |
| rd_en | input | 1 | RAM-mode read request |
| rd_addr | input | RAW | RAM-mode read address |
| rd_data | output | RD_W | Registered read data |
| rd_valid | output | 1 | rd_data was loaded at the last edge |
| push | input | 1 | FIFO-mode write request |
| pop | input | 1 | FIFO-mode read request |
| ae_level | input | AETW | Almost-empty threshold, in read words |
| af_level | input | AFTW | Almost-full threshold, in write words |
| full | output | 1 | No room for one more write word |
| empty | output | 1 | Less than one read word stored |
| almost_full | output | 1 | Free write words at or below af_level |
| almost_empty | output | 1 | Stored read words at or below ae_level |
| overflow | output | 1 | Sticky: a push was refused |
| underflow | output | 1 | Sticky: a pop was refused |

## Verification
The bench builds two copies of the block.

The first copy writes 4 bits and reads 1 bit. This brings the narrow group's bit order and the same-address collision within reach. With a 1,024-word fill, it also covers every FIFO flag, the refused push at full and the refused pop at empty.

The second copy writes 18 bits and reads 9 bits. This reaches the wide group. There, the last row and the two nine-bit halves of an eighteen-bit word show that all 4,608 bits are addressable.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    localparam int unsigned ROWS   = 256;
    localparam int unsigned ROW_W  = 18;
    localparam int unsigned ROW_AW = 8;

    typedef logic [ROW_W-1:0] row_t;

    typedef enum logic {
        MODE_RAM  = 1'b0,
        MODE_FIFO = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic almost_empty;
        logic empty;
    } level_flags_t;

    typedef struct packed {
        logic overflow;
        logic underflow;
    } err_flags_t;

    function automatic bit wide_group(input int unsigned w);
        return w >= 9;
    endfunction

    function automatic int unsigned row_bits_used(input int unsigned w);
        return wide_group(w) ? 18 : 16;
    endfunction

    function automatic int unsigned cap_bits(input int unsigned w);
        return row_bits_used(w) * ROWS;
    endfunction

    function automatic int unsigned depth_of(input int unsigned w);
        return cap_bits(w) / w;
    endfunction

    function automatic int unsigned words_per_row(input int unsigned w);
        return row_bits_used(w) / w;
    endfunction

    function automatic int unsigned slot_bits(input int unsigned w);
        return $clog2(words_per_row(w));
    endfunction

    function automatic int unsigned fifo_cap(input int unsigned ww, input int unsigned rw);
        return (cap_bits(ww) < cap_bits(rw)) ? cap_bits(ww) : cap_bits(rw);
    endfunction

    // logical bit inside a row -> physical column; the narrow group skips columns 8 and 17
    function automatic int unsigned phys_of(input int unsigned w, input int unsigned p);
        if (wide_group(w)) return p;
        return (p >= 8) ? p + 1 : p;
    endfunction

    function automatic bit phys_used(input int unsigned w, input int unsigned pb);
        if (wide_group(w)) return 1'b1;
        return (pb != 8) && (pb != 17);
    endfunction

    function automatic int unsigned logical_of(input int unsigned w, input int unsigned pb);
        if (wide_group(w)) return pb;
        return (pb > 8) ? pb - 1 : pb;
    endfunction

endpackage

// File: rtl/mwram_store.sv
module mwram_store
    import mwram_pkg::*;
#(
    parameter int unsigned WR_W = 4,
    parameter int unsigned RD_W = 1,
    localparam int unsigned WAW = $clog2(depth_of(WR_W)),
    localparam int unsigned RAW = $clog2(depth_of(RD_W))
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [WAW-1:0]  waddr,
    input  logic [WR_W-1:0] wdata,
    input  logic            re,
    input  logic [RAW-1:0]  raddr,
    output logic [RD_W-1:0] rdata
);

    localparam int unsigned WSB = slot_bits(WR_W);
    localparam int unsigned RSB = slot_bits(RD_W);
    localparam int unsigned RPR = words_per_row(RD_W);

    row_t mem [ROWS];

    logic [ROW_AW-1:0] wrow;
    logic [ROW_AW-1:0] rrow;
    row_t              wmask;
    row_t              wbits;
    row_t              rrow_data;

    assign wrow      = waddr[WAW-1 -: ROW_AW];
    assign rrow      = raddr[RAW-1 -: ROW_AW];
    assign rrow_data = mem[rrow];

    // write lanes: each physical column knows which slot and data bit feed it
    for (genvar pb = 0; pb < ROW_W; pb++) begin : g_wcol
        if (phys_used(WR_W, pb)) begin : g_used
            localparam int unsigned LP = logical_of(WR_W, pb);
            localparam int unsigned SL = LP / WR_W;
            localparam int unsigned BI = LP % WR_W;
            if (WSB == 0) begin : g_whole
                assign wmask[pb] = 1'b1;
            end else begin : g_slot
                assign wmask[pb] = (waddr[WSB-1:0] == WSB'(SL));
            end
            assign wbits[pb] = wdata[BI];
        end else begin : g_pad
            assign wmask[pb] = 1'b0;
            assign wbits[pb] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wrow] <= (mem[wrow] & ~wmask) | (wbits & wmask);
        end
    end

    // read lanes: every slot of the addressed row laid out as a candidate word
    logic [RPR-1:0][RD_W-1:0] rcand;
    logic [RD_W-1:0]          rword;

    for (genvar s = 0; s < RPR; s++) begin : g_rslot
        for (genvar i = 0; i < RD_W; i++) begin : g_rbit
            localparam int unsigned PB = phys_of(RD_W, s * RD_W + i);
            assign rcand[s][i] = rrow_data[PB];
        end
    end

    if (RSB == 0) begin : g_rwhole
        assign rword = rcand[0];
    end else begin : g_rsel
        assign rword = rcand[raddr[RSB-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= rword;
        end
    end

endmodule

// File: rtl/mwram_flags.sv
module mwram_flags
    import mwram_pkg::*;
#(
    parameter int unsigned WR_W = 4,
    parameter int unsigned RD_W = 1,
    localparam int unsigned CAP  = fifo_cap(WR_W, RD_W),
    localparam int unsigned LW   = $clog2(CAP + 1),
    localparam int unsigned AFTW = $clog2(depth_of(WR_W) + 1),
    localparam int unsigned AETW = $clog2(depth_of(RD_W) + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LW-1:0]   level,
    input  logic [AETW-1:0] ae_level,
    input  logic [AFTW-1:0] af_level,
    output level_flags_t    flags
);

    logic [31:0] lvl;
    logic [31:0] room;
    logic [31:0] ae_lim;
    logic [31:0] af_lim;

    assign lvl    = 32'(level);
    assign room   = CAP - lvl;
    assign ae_lim = (32'(ae_level) + 32'd1) * RD_W;
    assign af_lim = (32'(af_level) + 32'd1) * WR_W;

    always_comb begin
        flags.empty        = lvl < RD_W;
        flags.full         = room < WR_W;
        flags.almost_empty = lvl < ae_lim;
        flags.almost_full  = room < af_lim;
    end

    assert_full_empty_excl_R6 : assert property (@(posedge clk) disable iff (rst)
        !(flags.full && flags.empty));

    assert_empty_in_aempty_R7 : assert property (@(posedge clk) disable iff (rst)
        flags.empty |-> flags.almost_empty);

    assert_full_in_afull_R7 : assert property (@(posedge clk) disable iff (rst)
        flags.full |-> flags.almost_full);

endmodule

// File: rtl/mwram_fifo_ctl.sv
module mwram_fifo_ctl
    import mwram_pkg::*;
#(
    parameter int unsigned WR_W = 4,
    parameter int unsigned RD_W = 1,
    localparam int unsigned WAW = $clog2(depth_of(WR_W)),
    localparam int unsigned RAW = $clog2(depth_of(RD_W)),
    localparam int unsigned CAP = fifo_cap(WR_W, RD_W),
    localparam int unsigned LW  = $clog2(CAP + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  port_mode_e     mode,
    input  logic           push,
    input  logic           pop,
    input  logic           is_full,
    input  logic           is_empty,
    output logic           wr_go,
    output logic           rd_go,
    output logic [WAW-1:0] wptr,
    output logic [RAW-1:0] rptr,
    output logic [LW-1:0]  level,
    output err_flags_t     errs
);

    logic active;

    assign active = (mode == MODE_FIFO);
    assign wr_go  = active && push && !is_full;
    assign rd_go  = active && pop  && !is_empty;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_go) wptr <= wptr + 1'b1;
            if (rd_go) rptr <= rptr + 1'b1;
            level <= level + (wr_go ? LW'(WR_W) : '0) - (rd_go ? LW'(RD_W) : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            errs <= '0;
        end else begin
            if (active && push && is_full)  errs.overflow  <= 1'b1;
            if (active && pop  && is_empty) errs.underflow <= 1'b1;
        end
    end

    assert_level_bound_R6 : assert property (@(posedge clk) disable iff (rst)
        32'(level) <= CAP);

    assert_no_overflow_R8 : assert property (@(posedge clk) disable iff (rst)
        (active && push && is_full) |=> (wptr == $past(wptr)));

    assert_ovf_sticky_R8 : assert property (@(posedge clk) disable iff (rst)
        errs.overflow |=> errs.overflow);

    assert_no_underflow_R9 : assert property (@(posedge clk) disable iff (rst)
        (active && pop && is_empty) |=> (rptr == $past(rptr)));

    assert_unf_sticky_R9 : assert property (@(posedge clk) disable iff (rst)
        errs.underflow |=> errs.underflow);

endmodule

// File: rtl/mwram_fifo.sv
module mwram_fifo
    import mwram_pkg::*;
#(
    parameter int unsigned WR_W = 4,
    parameter int unsigned RD_W = 1,
    localparam int unsigned WAW  = $clog2(depth_of(WR_W)),
    localparam int unsigned RAW  = $clog2(depth_of(RD_W)),
    localparam int unsigned AFTW = $clog2(depth_of(WR_W) + 1),
    localparam int unsigned AETW = $clog2(depth_of(RD_W) + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_en,
    input  logic            wr_en,
    input  logic [WAW-1:0]  wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_en,
    input  logic [RAW-1:0]  rd_addr,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_valid,
    input  logic            push,
    input  logic            pop,
    input  logic [AETW-1:0] ae_level,
    input  logic [AFTW-1:0] af_level,
    output logic            full,
    output logic            empty,
    output logic            almost_full,
    output logic            almost_empty,
    output logic            overflow,
    output logic            underflow
);

    localparam int unsigned CAP = fifo_cap(WR_W, RD_W);
    localparam int unsigned LW  = $clog2(CAP + 1);

    port_mode_e     mode;
    logic           f_wr_go;
    logic           f_rd_go;
    logic [WAW-1:0] f_wptr;
    logic [RAW-1:0] f_rptr;
    logic [LW-1:0]  f_level;
    level_flags_t   lflags;
    err_flags_t     errs;

    logic           mem_we;
    logic           mem_re;
    logic [WAW-1:0] mem_waddr;
    logic [RAW-1:0] mem_raddr;

    assign mode = fifo_en ? MODE_FIFO : MODE_RAM;

    mwram_fifo_ctl #(.WR_W(WR_W), .RD_W(RD_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .push     (push),
        .pop      (pop),
        .is_full  (lflags.full),
        .is_empty (lflags.empty),
        .wr_go    (f_wr_go),
        .rd_go    (f_rd_go),
        .wptr     (f_wptr),
        .rptr     (f_rptr),
        .level    (f_level),
        .errs     (errs)
    );

    mwram_flags #(.WR_W(WR_W), .RD_W(RD_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .level    (f_level),
        .ae_level (ae_level),
        .af_level (af_level),
        .flags    (lflags)
    );

    always_comb begin
        if (mode == MODE_FIFO) begin
            mem_we    = f_wr_go;
            mem_waddr = f_wptr;
            mem_re    = f_rd_go;
            mem_raddr = f_rptr;
        end else begin
            mem_we    = wr_en;
            mem_waddr = wr_addr;
            mem_re    = rd_en;
            mem_raddr = rd_addr;
        end
    end

    mwram_store #(.WR_W(WR_W), .RD_W(RD_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= mem_re;
    end

    assign full         = lflags.full;
    assign empty        = lflags.empty;
    assign almost_full  = lflags.almost_full;
    assign almost_empty = lflags.almost_empty;
    assign overflow     = errs.overflow;
    assign underflow    = errs.underflow;

    assert_read_latency_R3 : assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && rd_en) |=> rd_valid);

    assert_no_valid_on_empty_R9 : assert property (@(posedge clk) disable iff (rst)
        (fifo_en && pop && empty) |=> !rd_valid);

    assert_ram_mode_clears_R11 : assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> empty);

endmodule

// File: tb/mwram_fifo_bench.sv
module mwram_fifo_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // narrow copy: write 4, read 1
    logic        a_fifo_en = 0, a_wr_en = 0, a_rd_en = 0, a_push = 0, a_pop = 0;
    logic [9:0]  a_wr_addr = '0;
    logic [3:0]  a_wr_data = '0;
    logic [11:0] a_rd_addr = '0;
    logic [12:0] a_ae = '0;
    logic [10:0] a_af = '0;
    logic [0:0]  a_rd_data;
    logic        a_rd_valid, a_full, a_empty, a_afull, a_aempty, a_ovf, a_unf;

    // wide copy: write 18, read 9
    logic        b_fifo_en = 0, b_wr_en = 0, b_rd_en = 0, b_push = 0, b_pop = 0;
    logic [7:0]  b_wr_addr = '0;
    logic [17:0] b_wr_data = '0;
    logic [8:0]  b_rd_addr = '0;
    logic [9:0]  b_ae = '0;
    logic [8:0]  b_af = '0;
    logic [8:0]  b_rd_data;
    logic        b_rd_valid, b_full, b_empty, b_afull, b_aempty, b_ovf, b_unf;

    mwram_fifo #(.WR_W(4), .RD_W(1)) u_mwram_fifo (
        .clk(clk), .rst(rst), .fifo_en(a_fifo_en),
        .wr_en(a_wr_en), .wr_addr(a_wr_addr), .wr_data(a_wr_data),
        .rd_en(a_rd_en), .rd_addr(a_rd_addr), .rd_data(a_rd_data), .rd_valid(a_rd_valid),
        .push(a_push), .pop(a_pop), .ae_level(a_ae), .af_level(a_af),
        .full(a_full), .empty(a_empty), .almost_full(a_afull), .almost_empty(a_aempty),
        .overflow(a_ovf), .underflow(a_unf)
    );

    mwram_fifo #(.WR_W(18), .RD_W(9)) u_mwram_fifo_wide (
        .clk(clk), .rst(rst), .fifo_en(b_fifo_en),
        .wr_en(b_wr_en), .wr_addr(b_wr_addr), .wr_data(b_wr_data),
        .rd_en(b_rd_en), .rd_addr(b_rd_addr), .rd_data(b_rd_data), .rd_valid(b_rd_valid),
        .push(b_push), .pop(b_pop), .ae_level(b_ae), .af_level(b_af),
        .full(b_full), .empty(b_empty), .almost_full(b_afull), .almost_empty(b_aempty),
        .overflow(b_ovf), .underflow(b_unf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference models, addressed by logical bit
    logic [4095:0] ref_a = '0;
    logic [4607:0] ref_b = '0;
    logic          mq[$];
    int            lvl_m = 0;
    bit            ovf_m = 0, unf_m = 0;

    // scoreboard of expected narrow-copy read results
    logic  exp_q[$];
    string tag_q[$];

    always @(negedge clk) begin
        if (!rst && a_rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected rd_valid", 32'(a_rd_valid), 32'd0);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(a_rd_data), 32'(e));
            end
        end
    end

    // RAM-mode cycle on the narrow copy; starts and ends just after a falling edge
    task automatic a_ram(input bit we, input int wa, input logic [3:0] wd,
                         input bit re, input int ra, input string tag);
        if (re) begin
            exp_q.push_back(ref_a[ra]);
            tag_q.push_back(tag);
        end
        a_wr_en = we; a_wr_addr = 10'(wa); a_wr_data = wd;
        a_rd_en = re; a_rd_addr = 12'(ra);
        @(negedge clk);
        if (we) ref_a[wa*4 +: 4] = wd;
        a_wr_en = 0; a_rd_en = 0;
    endtask

    task automatic a_flag_chk(input string tag);
        check({tag, " R6 empty"}, 32'(a_empty), 32'(lvl_m < 1));
        check({tag, " R6 full"},  32'(a_full),  32'(4096 - lvl_m < 4));
        check({tag, " R7 almost_empty"}, 32'(a_aempty), 32'(lvl_m < (int'(a_ae) + 1)));
        check({tag, " R7 almost_full"},  32'(a_afull),  32'((4096 - lvl_m) < (int'(a_af) + 1) * 4));
        check({tag, " R8 overflow"},  32'(a_ovf), 32'(ovf_m));
        check({tag, " R9 underflow"}, 32'(a_unf), 32'(unf_m));
    endtask

    // FIFO-mode cycle; port enables and addresses are driven with noise (R5)
    task automatic a_fifo(input bit ps, input bit pp, input logic [3:0] d, input string tag);
        bit acc_w, acc_r;
        acc_w = ps && (lvl_m + 4 <= 4096);
        acc_r = pp && (lvl_m >= 1);
        if (ps && !acc_w) ovf_m = 1;
        if (pp && !acc_r) unf_m = 1;
        if (acc_r) begin
            exp_q.push_back(mq.pop_front());
            tag_q.push_back(tag);
        end
        if (acc_w) for (int k = 0; k < 4; k++) mq.push_back(d[k]);
        lvl_m += (acc_w ? 4 : 0) - (acc_r ? 1 : 0);
        a_push = ps; a_pop = pp; a_wr_data = d;
        a_wr_en = 1; a_rd_en = 1;
        a_wr_addr = 10'(lvl_m * 37 + 5); a_rd_addr = 12'(lvl_m * 91 + 2);
        @(negedge clk);
        a_push = 0; a_pop = 0; a_wr_en = 0; a_rd_en = 0;
        a_flag_chk(tag);
    endtask

    task automatic b_write(input int wa, input logic [17:0] wd);
        b_wr_en = 1; b_wr_addr = 8'(wa); b_wr_data = wd;
        @(negedge clk);
        ref_b[wa*18 +: 18] = wd;
        b_wr_en = 0;
    endtask

    task automatic b_read(input int ra, input string tag);
        logic [8:0] e;
        e = ref_b[ra*9 +: 9];
        b_rd_en = 1; b_rd_addr = 9'(ra);
        @(negedge clk);
        b_rd_en = 0;
        check({tag, " data"}, 32'(b_rd_data), 32'(e));
        check("R3 wide rd_valid", 32'(b_rd_valid), 32'd1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R12: reset state on both copies
        check("R12 rd_valid", 32'(a_rd_valid), 32'd0);
        check("R12 rd_data",  32'(a_rd_data),  32'd0);
        check("R12 empty",    32'(a_empty),    32'd1);
        check("R12 full",     32'(a_full),     32'd0);
        check("R12 overflow", 32'(a_ovf),      32'd0);
        check("R12 underflow",32'(a_unf),      32'd0);
        check("R12 wide empty", 32'(b_empty),  32'd1);
        check("R12 wide rd_data", 32'(b_rd_data), 32'd0);

        // R2: nibbles written, bits read back lowest address first
        a_ram(1, 0, 4'h6, 0, 0, "");
        a_ram(1, 1, 4'hB, 0, 0, "");
        a_ram(1, 2, 4'h1, 0, 0, "");
        a_ram(1, 3, 4'hE, 0, 0, "");
        for (int b = 0; b < 16; b++) a_ram(0, 0, 0, 1, b, "R2 narrow-to-serial");

        // R3: with no read, rd_valid drops and rd_data holds the last bit (bit 15 = 1)
        @(negedge clk);
        check("R3 rd_valid idle", 32'(a_rd_valid), 32'd0);
        check("R3 rd_data hold",  32'(a_rd_data),  32'd1);

        // R4: same-location write and read return the old value
        a_ram(1, 5, 4'hA, 0, 0, "");
        a_ram(1, 5, 4'h5, 1, 20, "R4 old data bit0");
        a_ram(0, 0, 0, 1, 20, "R4 new data bit0");
        a_ram(0, 0, 0, 1, 21, "R4 new data bit1");

        // R1: top of the narrow range
        a_ram(1, 1023, 4'h9, 0, 0, "");
        a_ram(0, 0, 0, 1, 4095, "R1 narrow last bit");
        a_ram(0, 0, 0, 1, 4092, "R1 narrow last word lsb");

        // R1/R2: wide group, full 4,608-bit range
        b_write(255, 18'h2A5C3);
        b_write(0,   18'h10F0F);
        b_write(128, 18'h3_1E07);
        b_read(511, "R1 wide last half");
        b_read(510, "R1 wide last low half");
        b_read(0,   "R2 wide low half");
        b_read(1,   "R2 wide high half");
        b_read(257, "R2 wide mid high half");

        // R11: push in RAM mode has no effect on the wide copy
        b_push = 1; b_pop = 1;
        @(negedge clk);
        b_push = 0; b_pop = 0;
        check("R11 wide empty", 32'(b_empty), 32'd1);
        check("R11 wide overflow", 32'(b_ovf), 32'd0);
        check("R11 wide underflow", 32'(b_unf), 32'd0);

        // FIFO mode on the narrow copy
        a_ae = 13'd2; a_af = 11'd3;
        a_fifo_en = 1;
        @(negedge clk);
        a_flag_chk("R6 entry");
        a_fifo(1, 0, 4'hC, "R5 push");
        a_fifo(1, 0, 4'h3, "R5 push");
        a_fifo(1, 0, 4'h9, "R5 push");
        for (int n = 0; n < 5; n++) a_fifo(0, 1, 0, "R5 pop order");
        for (int n = 0; n < 4; n++) a_fifo(1, 1, 4'(n * 3 + 1), "R10 push+pop");
        while (lvl_m > 0) a_fifo(0, 1, 0, "R5 drain");

        // R9: pop on empty
        a_fifo(0, 1, 0, "R9 pop empty");
        check("R9 no rd_valid", 32'(a_rd_valid), 32'd0);

        // R8: fill, refuse one more, then drain and compare every bit
        for (int n = 0; n < 1024; n++) a_fifo(1, 0, 4'(n * 5 + 3), "R8 fill");
        a_fifo(1, 0, 4'hF, "R8 push full");
        for (int n = 0; n < 4096; n++) a_fifo(0, 1, 0, "R8 drain after refuse");

        // R11: back to RAM mode, push and pop ignored
        a_fifo_en = 0;
        lvl_m = 0; mq.delete();
        @(negedge clk);
        a_push = 1; a_pop = 1;
        @(negedge clk);
        a_push = 0; a_pop = 0;
        check("R11 no rd_valid", 32'(a_rd_valid), 32'd0);
        a_flag_chk("R11 RAM mode");

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);

        done = 1;
        summary();
        $finish;
    end

endmodule